// File: doc/BRIEF.md
# Dual Accumulator Word Logic Unit

This block is a small bitwise engine built around two accumulator registers. A primary accumulator holds the most recent operand or result. A secondary accumulator holds the operand loaded before it. Each load pushes the primary value down into the secondary register and captures the new operand. Two loads in a row therefore set up a pair of operands. A logic command then combines the secondary register (first operand) with the primary register (second operand), one bit position at a time, and writes the result back into the primary register.

Each command selects a width. In word mode only the low 16 bits take part. In double-word mode all 32 bits take part. The supported functions are AND, OR, XOR and ones complement, and no bit position ever influences another. A transfer command presents the primary accumulator, masked to the selected width, on the output port together with a one-cycle write strobe. The usual consumers are masking, forcing bits high, and finding which bits changed between two samples and in which direction.

Top module: `dacc_unit`

## Requirements
- R1: A synchronous active-low reset clears both accumulators to zero and drives `out_wr` low and `out_data` to zero.
- R2: A load (`cmd_op` = 1) copies the primary accumulator into the secondary one. In the same cycle it writes `cmd_operand` into the primary accumulator. In word mode (`cmd_dword` = 0) the upper 16 bits of the written value are zero.
- R3: AND (`cmd_op` = 2), OR (3) and XOR (4) combine the secondary accumulator with the primary one bit by bit and place the result in the primary accumulator. The secondary accumulator keeps its value.
- R4: In word mode, AND, OR, XOR and complement change only bits 15:0 of the primary accumulator. Bits 31:16 keep their previous value.
- R5: Complement (`cmd_op` = 5) inverts every bit of the primary accumulator within the selected width.
- R6: A transfer (`cmd_op` = 6) drives the primary accumulator onto `out_data` in the cycle after the command. In word mode bits 31:16 of that value read as zero. `out_wr` is high for that one cycle, and both accumulators keep their values.
- R7: Without a transfer, `out_wr` is low in the following cycle and `out_data` keeps its last presented value. This holds even when a load changes the primary accumulator in that cycle.
- R8: A command with `cmd_valid` low, a no-operation code (0), or an unused code (7 to 15) leaves both accumulators unchanged.
- R9: Loading old, loading new, XOR, loading new again and then AND yields the bits that went from 0 to 1 (old 1010, new 1100 gives 0100). The same sequence with old loaded in the third load yields the bits that went from 1 to 0 (0010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 4 | Command code |
| cmd_dword | input | 1 | 1 selects 32-bit width, 0 selects 16-bit width |
| cmd_operand | input | 32 | Operand captured by a load |
| out_data | output | 32 | Value presented by the last transfer |
| out_wr | output | 1 | One-cycle strobe marking a transfer |

## Verification
Two functions can meet in one cycle: the presented output of a transfer and a load that rewrites the primary accumulator. The bench issues a transfer and then a load on the very next edge. While the load's effect lands, it checks that the strobe drops and that `out_data` still shows the transferred value rather than the new operand. A later transfer then shows that the load itself took effect.

// File: rtl/dacc_pkg.sv
// Package: command codes shared by the accumulator logic unit and its bench.
// Assumes a 4-bit command field; codes 7..15 are reserved and act as no-ops.
package dacc_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_LOAD = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_INV  = 4'd5,
        OP_XFER = 4'd6
    } dacc_op_e;
endpackage

// File: rtl/dacc_logic.sv
// Bitwise combine unit: splits the accumulators into lanes of LANE_W bits.
// Lane 0 is always active. Upper lanes are active only in full-width mode;
// an inactive lane passes the primary accumulator through unchanged.
// Assumes DATA_W is a multiple of LANE_W. Purely combinational.
module dacc_logic
    import dacc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned LANE_W = 16
) (
    input  dacc_op_e           op,
    input  logic               full_width,
    input  logic [DATA_W-1:0]  prim,
    input  logic [DATA_W-1:0]  sec,
    output logic [DATA_W-1:0]  result
);
    localparam int unsigned LANES = DATA_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] p_l;
        logic [LANE_W-1:0] s_l;
        logic [LANE_W-1:0] r_l;
        logic              lane_on;

        assign p_l     = prim[g*LANE_W +: LANE_W];
        assign s_l     = sec[g*LANE_W +: LANE_W];
        assign lane_on = (g == 0) || full_width;

        // Per-lane function select; no bit crosses into its neighbour.
        always_comb begin
            case (op)
                OP_AND:  r_l = s_l & p_l;
                OP_OR:   r_l = s_l | p_l;
                OP_XOR:  r_l = s_l ^ p_l;
                OP_INV:  r_l = ~p_l;
                default: r_l = p_l;
            endcase
        end

        assign result[g*LANE_W +: LANE_W] = lane_on ? r_l : p_l;
    end
endmodule

// File: rtl/dacc_regs.sv
// Accumulator pair. A load shifts primary into secondary and captures the
// new value; a logic write replaces primary only. Assumes load and logic
// writes are never requested together (the decoder guarantees it).
module dacc_regs #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              calc_en,
    input  logic [DATA_W-1:0] calc_val,
    output logic [DATA_W-1:0] prim,
    output logic [DATA_W-1:0] sec
);
    // Primary accumulator: new operand on load, result on a logic write.
    always_ff @(posedge clk) begin
        if (!rst_n)       prim <= '0;
        else if (load_en) prim <= load_val;
        else if (calc_en) prim <= calc_val;
    end

    // Secondary accumulator: receives the old primary value on each load.
    always_ff @(posedge clk) begin
        if (!rst_n)       sec <= '0;
        else if (load_en) sec <= prim;
    end

    AST_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> sec == $past(prim));                               // R2
    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> prim == $past(load_val));                          // R2
    AST_CALC_KEEPS_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        calc_en && !load_en |=> $stable(sec));                         // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en && !calc_en |=> $stable(prim) && $stable(sec));       // R8
endmodule

// File: rtl/dacc_xfer.sv
// Output stage: on a transfer, registers the primary accumulator masked to
// the chosen width and raises the write strobe for one cycle. Between
// transfers the presented data is held.
module dacc_xfer #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_en,
    input  logic [DATA_W-1:0] width_mask,
    input  logic [DATA_W-1:0] prim,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wr
);
    // Capture the masked accumulator on a transfer; hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_data <= '0;
        else if (xfer_en) out_data <= prim & width_mask;
    end

    // The strobe follows the transfer request by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_wr <= 1'b0;
        else        out_wr <= xfer_en;
    end

    AST_XFER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> out_wr);                                           // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_en |=> !out_wr && $stable(out_data));                    // R7
endmodule

// File: rtl/dacc_unit.sv
// Top of the dual accumulator word logic unit. Decodes one command per
// cycle, builds the width mask, and wires the combine unit, the
// accumulator pair and the output stage. Assumes DATA_W = 2 * WORD_W.
module dacc_unit
    import dacc_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic              cmd_dword,
    input  logic [DATA_W-1:0] cmd_operand,
    output logic [DATA_W-1:0] out_data,
    output logic              out_wr
);
    localparam logic [DATA_W-1:0] WORD_MASK = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

    dacc_op_e          op;
    logic              load_en;
    logic              calc_en;
    logic              xfer_en;
    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] prim;
    logic [DATA_W-1:0] sec;
    logic [DATA_W-1:0] calc_val;

    // Command decode: one action per valid cycle, reserved codes ignored.
    always_comb begin
        op      = dacc_op_e'(cmd_op);
        load_en = cmd_valid && (cmd_op == OP_LOAD);
        calc_en = cmd_valid && (cmd_op == OP_AND || cmd_op == OP_OR ||
                                cmd_op == OP_XOR || cmd_op == OP_INV);
        xfer_en = cmd_valid && (cmd_op == OP_XFER);
    end

    assign width_mask = cmd_dword ? {DATA_W{1'b1}} : WORD_MASK;

    dacc_logic #(.DATA_W(DATA_W), .LANE_W(WORD_W)) u_logic (
        .op         (op),
        .full_width (cmd_dword),
        .prim       (prim),
        .sec        (sec),
        .result     (calc_val)
    );

    dacc_regs #(.DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .load_val (cmd_operand & width_mask),
        .calc_en  (calc_en),
        .calc_val (calc_val),
        .prim     (prim),
        .sec      (sec)
    );

    dacc_xfer #(.DATA_W(DATA_W)) u_xfer (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_en    (xfer_en),
        .width_mask (width_mask),
        .prim       (prim),
        .out_data   (out_data),
        .out_wr     (out_wr)
    );

    AST_WORD_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        calc_en && !cmd_dword |=> prim[DATA_W-1:WORD_W] == $past(prim[DATA_W-1:WORD_W])); // R4
    AST_XFER_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> $stable(prim) && $stable(sec));                    // R6
endmodule

// File: tb/dacc_unit_tb.sv
module dacc_unit_tb;
    typedef struct packed {
        logic        v;
        logic [3:0]  op;
        logic        dw;
        logic [31:0] opnd;
        logic        ewr;
        logic [31:0] edat;
    } vec_t;

    localparam int NV = 36;
    // Fields: valid, op, dword, operand, expected strobe, expected data.
    localparam vec_t VEC [NV] = '{
        '{1'b1, 4'd1, 1'b1, 32'hF0F0_1234, 1'b0, 32'h0},          // R2 load
        '{1'b1, 4'd1, 1'b1, 32'h0FF0_FF00, 1'b0, 32'h0},          // R2 load
        '{1'b1, 4'd2, 1'b1, 32'h0,         1'b0, 32'h0},          // R3 AND
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h00F0_1200},  // R3 result
        '{1'b1, 4'd6, 1'b0, 32'h0,         1'b1, 32'h0000_1200},  // R6 word mask
        '{1'b1, 4'd1, 1'b1, 32'hAAAA_5555, 1'b0, 32'h0},
        '{1'b1, 4'd3, 1'b0, 32'h0,         1'b0, 32'h0},          // R4 OR word
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'hAAAA_5755},  // R4
        '{1'b1, 4'd5, 1'b0, 32'h0,         1'b0, 32'h0},          // R5 INV word
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'hAAAA_A8AA},  // R5 R4
        '{1'b1, 4'd5, 1'b1, 32'h0,         1'b0, 32'h0},          // R5 INV dword
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h5555_5755},  // R5
        '{1'b1, 4'd4, 1'b1, 32'h0,         1'b0, 32'h0},          // R3 XOR
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h55A5_4555},  // R3
        '{1'b1, 4'd3, 1'b1, 32'h0,         1'b0, 32'h0},          // R3 sec kept
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h55F5_5755},  // R3
        '{1'b0, 4'd1, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0},          // R8 invalid
        '{1'b1, 4'd7, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0},          // R8 unused code
        '{1'b1, 4'd0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0},          // R8 nop
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h55F5_5755},  // R8
        '{1'b1, 4'd1, 1'b0, 32'h1234_ABCD, 1'b0, 32'h0},          // R2 word load
        '{1'b1, 4'd6, 1'b1, 32'h0,         1'b1, 32'h0000_ABCD},  // R2
        '{1'b1, 4'd1, 1'b0, 32'h0000_000A, 1'b0, 32'h0},          // R9 rising
        '{1'b1, 4'd1, 1'b0, 32'h0000_000C, 1'b0, 32'h0},
        '{1'b1, 4'd4, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 4'd1, 1'b0, 32'h0000_000C, 1'b0, 32'h0},
        '{1'b1, 4'd2, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 4'd6, 1'b0, 32'h0,         1'b1, 32'h0000_0004},  // R9
        '{1'b1, 4'd1, 1'b0, 32'h0000_000A, 1'b0, 32'h0},          // R9 falling
        '{1'b1, 4'd1, 1'b0, 32'h0000_000C, 1'b0, 32'h0},
        '{1'b1, 4'd4, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 4'd1, 1'b0, 32'h0000_000A, 1'b0, 32'h0},
        '{1'b1, 4'd2, 1'b0, 32'h0,         1'b0, 32'h0},
        '{1'b1, 4'd6, 1'b0, 32'h0,         1'b1, 32'h0000_0002},  // R9
        '{1'b1, 4'd6, 1'b0, 32'h0,         1'b1, 32'h0000_0002},  // R6 back to back
        '{1'b1, 4'd0, 1'b0, 32'h0,         1'b0, 32'h0}           // R7 strobe drops
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_op = 4'd0;
    logic        cmd_dword = 1'b0;
    logic [31:0] cmd_operand = 32'h0;
    logic [31:0] out_data;
    logic        out_wr;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    dacc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_dword(cmd_dword), .cmd_operand(cmd_operand),
        .out_data(out_data), .out_wr(out_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Apply one command at the falling edge, then sample just after the rising edge.
    task automatic step(input logic v, input logic [3:0] op, input logic dw, input logic [31:0] d);
        @(negedge clk);
        cmd_valid = v; cmd_op = op; cmd_dword = dw; cmd_operand = d;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk("R1 strobe in reset", {31'b0, out_wr}, 32'h0);
        chk("R1 data in reset", out_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        step(1'b1, 4'd6, 1'b1, 32'h0);
        chk("R1 accumulator zero after reset", out_data, 32'h0);
        chk("R1 strobe", {31'b0, out_wr}, 32'h1);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].v, VEC[i].op, VEC[i].dw, VEC[i].opnd);
            chk($sformatf("R6/R7 strobe row %0d", i), {31'b0, out_wr}, {31'b0, VEC[i].ewr});
            if (VEC[i].ewr)
                chk($sformatf("table row %0d data", i), out_data, VEC[i].edat);
        end

        // R7: a load right after a transfer must not disturb the presented data.
        step(1'b1, 4'd1, 1'b1, 32'hDEAD_BEEF);
        step(1'b1, 4'd6, 1'b1, 32'h0);
        chk("R6 transfer before load", out_data, 32'hDEAD_BEEF);
        step(1'b1, 4'd1, 1'b1, 32'h1357_9BDF);
        chk("R7 strobe low during load", {31'b0, out_wr}, 32'h0);
        chk("R7 data held during load", out_data, 32'hDEAD_BEEF);
        step(1'b1, 4'd6, 1'b1, 32'h0);
        chk("R2 load landed", out_data, 32'h1357_9BDF);
        step(1'b1, 4'd2, 1'b1, 32'h0);
        step(1'b1, 4'd6, 1'b1, 32'h0);
        chk("R6 accumulators kept by transfer", out_data, 32'hDEAD_BEEF & 32'h1357_9BDF);

        // R1: reset in mid-run clears both accumulators.
        do_reset();
        step(1'b1, 4'd3, 1'b1, 32'h0);
        step(1'b1, 4'd6, 1'b1, 32'h0);
        chk("R1 both accumulators cleared", out_data, 32'h0);
        step(1'b1, 4'd0, 1'b1, 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule